// File: doc/BRIEF.md
# Two-Segment Fibonacci Pseudorandom Generator

This block produces a pseudorandom word from two separate Fibonacci linear-feedback shift registers. The upper segment is SEG1_W bits wide and steps on every enabled clock. The lower segment is SEG2_W bits wide and steps only once in each full cycle of the upper segment. A small modulo counter, which counts enabled steps, decides when the lower segment moves. Because the two segments are chained this way, the joined word cycles with period (2^SEG1_W − 1)(2^SEG2_W − 1). It does not cycle with the period of a single register of the full width. Each segment can be 2 to 8 bits wide.

A synchronous reset loads a seed into each segment and clears the step counter. A seed of all zeros would lock a segment, so the block loads the value 1 into any segment whose seed is zero. The generator holds its complete state while the step enable is low, which lets the surrounding logic take one word for each enabled step.

Top module: `tseg_lfsr_rng`

## Requirements
- R1: On each clock edge with step_en high and rst low, segment 1 shifts one place toward its MSB. The XOR of its tapped stages enters bit 0. rnd_out carries segment 1 in its upper SEG1_W bits and segment 2 in its lower SEG2_W bits.
- R2: Segment 2 shifts only on the enabled step that completes P1 = 2^SEG1_W − 1 enabled steps since the last reset or the last segment-2 shift. With a 2:4 split, seed 01 and seed 0001, the output runs 17, 49, 33, 18, 50, 34, 20.
- R3: The feedback taps are set by the segment width. Bit k holds stage k+1. The tapped bits are {1,0} for width 2, {2,1} for 3, {3,2} for 4, {4,2} for 5, {5,4} for 6, {6,5} for 7 and {7,5,4,3} for 8. With a 3:3 split and both seeds 001, the output runs 9, 17, 41, 25, 57, 49, 33, 10.
- R4: Starting from reset, rnd_out first returns to its reset value after exactly (2^SEG1_W − 1)(2^SEG2_W − 1) enabled steps: 49 for 3:3, 45 for 2:4 and 225 for 4:4.
- R5: Outside reset, neither segment is ever all zeros.
- R6: A clock edge with rst high loads seed_hi into segment 1 and seed_lo into segment 2, and clears the step counter. This also applies in the middle of a run.
- R7: A seed of all zeros for either segment loads the value 1 into that segment instead.
- R8: While step_en is low, both segments and the step counter hold their values, so rnd_out does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset; loads the seeds and clears the counter |
| step_en | input | 1 | Advances the generator by one step |
| seed_hi | input | SEG1_W | Seed for segment 1 |
| seed_lo | input | SEG2_W | Seed for segment 2 |
| rnd_out | output | SEG1_W+SEG2_W | Joined output word, segment 1 in the upper bits |

## Verification
The assertions assume that rst is high at the first clock edge. They also assume that seed_hi and seed_lo are stable while rst is high, so that the loaded state is well defined. The bench asserts rst before the first edge and changes the seeds only at negative edges, while the block is held in reset or idle. step_en is pulsed for exactly one clock per step, or held low for whole cycles. As a result, every enabled edge is counted by the bench model in the same way as by the divider.

// File: rtl/tseg_pkg.sv
package tseg_pkg;

  localparam int MIN_SEG_W = 2;
  localparam int MAX_SEG_W = 8;

  // Feedback tap mask for a segment of width w; bit k stands for stage k+1.
  function automatic logic [MAX_SEG_W-1:0] tap_mask(input int w);
    logic [MAX_SEG_W-1:0] m;
    case (w)
      2:       m = 8'b0000_0011;
      3:       m = 8'b0000_0110;
      4:       m = 8'b0000_1100;
      5:       m = 8'b0001_0100;
      6:       m = 8'b0011_0000;
      7:       m = 8'b0110_0000;
      8:       m = 8'b1011_1000;
      default: m = '0;
    endcase
    return m;
  endfunction

  // Length of the maximal cycle of a segment of width w.
  function automatic int seg_period(input int w);
    return (1 << w) - 1;
  endfunction

  // Width needed to count 0 .. p-1.
  function automatic int cnt_width(input int p);
    return (p > 1) ? $clog2(p) : 1;
  endfunction

endpackage

// File: rtl/tseg_fib_seg.sv
module tseg_fib_seg #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv,
  input  logic [W-1:0] seed,
  output logic [W-1:0] state
);
  import tseg_pkg::*;

  localparam logic [W-1:0] TAPS = W'(tap_mask(W));
  localparam logic [W-1:0] FALLBACK = W'(1);

  logic [W-1:0] q;
  logic [W-1:0] load_val;
  logic         seed_zero;
  logic         fb;

  assign seed_zero = (seed == '0);
  assign load_val  = seed_zero ? FALLBACK : seed;
  assign fb        = ^(q & TAPS);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= load_val;
    end else if (adv) begin
      q <= {q[W-2:0], fb};
    end
  end

  assign state = q;

endmodule

// File: rtl/tseg_step_div.sv
module tseg_step_div #(
  parameter int P  = 7,
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  output logic          wrap,
  output logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] LAST = CW'(P - 1);

  logic [CW-1:0] c;
  logic          at_last;

  assign at_last = (c == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      c <= '0;
    end else if (en) begin
      if (at_last) c <= '0;
      else         c <= c + CW'(1);
    end
  end

  assign wrap = en && at_last;
  assign cnt  = c;

endmodule

// File: rtl/tseg_lfsr_rng.sv
module tseg_lfsr_rng #(
  parameter int SEG1_W = 3,
  parameter int SEG2_W = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     step_en,
  input  logic [SEG1_W-1:0]        seed_hi,
  input  logic [SEG2_W-1:0]        seed_lo,
  output logic [SEG1_W+SEG2_W-1:0] rnd_out
);
  import tseg_pkg::*;

  localparam int P1 = seg_period(SEG1_W);
  localparam int CW = cnt_width(P1);

  // Internal events brought out by name for the checker.
  logic              seg1_adv;
  logic              seg2_adv;
  logic [SEG1_W-1:0] seg1_q;
  logic [SEG2_W-1:0] seg2_q;
  logic [CW-1:0]     div_cnt;

  assign seg1_adv = step_en;

  tseg_step_div #(.P(P1), .CW(CW)) u_div (
    .clk  (clk),
    .rst  (rst),
    .en   (seg1_adv),
    .wrap (seg2_adv),
    .cnt  (div_cnt)
  );

  tseg_fib_seg #(.W(SEG1_W)) u_seg1 (
    .clk   (clk),
    .rst   (rst),
    .adv   (seg1_adv),
    .seed  (seed_hi),
    .state (seg1_q)
  );

  tseg_fib_seg #(.W(SEG2_W)) u_seg2 (
    .clk   (clk),
    .rst   (rst),
    .adv   (seg2_adv),
    .seed  (seed_lo),
    .state (seg2_q)
  );

  assign rnd_out = {seg1_q, seg2_q};

endmodule

// File: rtl/tseg_lfsr_chk.sv
module tseg_lfsr_chk #(
  parameter int N1 = 3,
  parameter int N2 = 3,
  parameter int CW = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             step_en,
  input logic             seg2_adv,
  input logic [N1-1:0]    seg1_q,
  input logic [N2-1:0]    seg2_q,
  input logic [CW-1:0]    div_cnt,
  input logic [N1+N2-1:0] rnd_out
);
  localparam int P1 = (1 << N1) - 1;

  // R5
  seg1_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    seg1_q != '0);

  // R5
  seg2_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    seg2_q != '0);

  // R8
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !step_en |=> $stable(rnd_out));

  // R2
  seg2_moves_on_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    !seg2_adv |=> $stable(seg2_q));

  // R2
  wrap_needs_step_chk: assert property (@(posedge clk) disable iff (rst)
    seg2_adv |-> step_en);

  // R2
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    int'(div_cnt) < P1);

  // R6
  cnt_clear_chk: assert property (@(posedge clk)
    rst |=> div_cnt == '0);

  // R1
  seg1_moves_chk: assert property (@(posedge clk) disable iff (rst)
    step_en |=> seg1_q != $past(seg1_q));

endmodule

bind tseg_lfsr_rng tseg_lfsr_chk #(.N1(SEG1_W), .N2(SEG2_W), .CW(CW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .step_en  (step_en),
  .seg2_adv (seg2_adv),
  .seg1_q   (seg1_q),
  .seg2_q   (seg2_q),
  .div_cnt  (div_cnt),
  .rnd_out  (rnd_out)
);

// File: tb/sim_tseg_lfsr_rng.sv
module sim_tseg_lfsr_rng;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst = 1'b1;
  logic       step_en = 1'b0;
  logic [2:0] sa1 = 3'd1, sa2 = 3'd1;
  logic [1:0] sb1 = 2'd1;
  logic [3:0] sb2 = 4'd1;
  logic [3:0] sc1 = 4'd1, sc2 = 4'd1;
  logic [5:0] oa, ob;
  logic [7:0] oc;

  int n_run = 0;
  int n_fail = 0;

  // R3 / R1 expected 3:3 walk; R2 expected 2:4 walk; R3 first 4:4 words
  localparam logic [5:0] SEQ33 [8] = '{6'd9, 6'd17, 6'd41, 6'd25, 6'd57, 6'd49, 6'd33, 6'd10};
  localparam logic [5:0] SEQ24 [7] = '{6'd17, 6'd49, 6'd33, 6'd18, 6'd50, 6'd34, 6'd20};
  localparam logic [7:0] SEQ44 [4] = '{8'd17, 8'd33, 8'd65, 8'd145};

  tseg_lfsr_rng #(.SEG1_W(3), .SEG2_W(3)) u0 (
    .clk(clk), .rst(rst), .step_en(step_en), .seed_hi(sa1), .seed_lo(sa2), .rnd_out(oa));
  tseg_lfsr_rng #(.SEG1_W(2), .SEG2_W(4)) u1 (
    .clk(clk), .rst(rst), .step_en(step_en), .seed_hi(sb1), .seed_lo(sb2), .rnd_out(ob));
  tseg_lfsr_rng #(.SEG1_W(4), .SEG2_W(4)) u2 (
    .clk(clk), .rst(rst), .step_en(step_en), .seed_hi(sc1), .seed_lo(sc2), .rnd_out(oc));

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    step_en = 1'b0;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic step();
    step_en = 1'b1;
    @(negedge clk);
    step_en = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int ret_a, ret_b, ret_c, zero_hits;
    logic [5:0] held;

    // R6: reset state
    do_reset();
    chk("R6 reset 3:3", int'(oa), 9);
    chk("R6 reset 2:4", int'(ob), 17);
    chk("R6 reset 4:4", int'(oc), 17);

    // Vector walk: R1/R3 (3:3), R2 (2:4), R3 (4:4)
    for (int k = 1; k < 8; k++) begin
      step();
      chk("R3 3:3 sequence", int'(oa), int'(SEQ33[k]));
      if (k < 7) chk("R2 2:4 sequence", int'(ob), int'(SEQ24[k]));
      if (k < 4) chk("R3 4:4 sequence", int'(oc), int'(SEQ44[k]));
      if (k == 2) chk("R2 seg2 still at seed", int'(ob[3:0]), 1);
      if (k == 3) chk("R2 seg2 first change", int'(ob[3:0]), 2);
      if (k == 6) chk("R1 3:3 seg2 held", int'(oa[2:0]), 1);
    end

    // R4 / R5: full periods from reset
    do_reset();
    ret_a = 0; ret_b = 0; ret_c = 0; zero_hits = 0;
    for (int s = 1; s <= 240; s++) begin
      step();
      if (oa[5:3] == 0 || oa[2:0] == 0) zero_hits++;
      if (ob[5:4] == 0 || ob[3:0] == 0) zero_hits++;
      if (oc[7:4] == 0 || oc[3:0] == 0) zero_hits++;
      if (ret_a == 0 && oa == 6'd9)  ret_a = s;
      if (ret_b == 0 && ob == 6'd17) ret_b = s;
      if (ret_c == 0 && oc == 8'd17) ret_c = s;
    end
    chk("R4 period 3:3", ret_a, 49);
    chk("R4 period 2:4", ret_b, 45);
    chk("R4 period 4:4", ret_c, 225);
    chk("R5 zero segment seen", zero_hits, 0);

    // R8: hold with step_en low, counter held too
    do_reset();
    step();
    step();
    held = oa;
    for (int h = 0; h < 5; h++) begin
      @(negedge clk);
      chk("R8 hold", int'(oa), int'(held));
    end
    for (int k = 3; k < 8; k++) step();
    chk("R8 counter held, seg2 step at 7th", int'(oa), 10);

    // R6: reset mid-run clears the counter
    step();
    step();
    do_reset();
    chk("R6 mid-run reload", int'(oa), 9);
    for (int k = 1; k < 7; k++) step();
    chk("R6 seg2 waits after reset", int'(oa), 33);
    step();
    chk("R6 seg2 steps after P1", int'(oa), 10);

    // R7: zero seeds fall back to 1
    sa1 = 3'd0; sa2 = 3'd0; sb1 = 2'd0; sb2 = 4'd5; sc1 = 4'd0; sc2 = 4'd3;
    do_reset();
    chk("R7 zero seeds 3:3", int'(oa), 9);
    chk("R7 zero seed hi 2:4", int'(ob), 21);
    chk("R7 zero seed hi 4:4", int'(oc), 19);
    step();
    chk("R7 run after fallback", int'(oa), 17);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule